// File: doc/BRIEF.md
# User-Mode Memory Address Guard

This block sits on the data-memory path of a 32-bit core. The core keeps its privilege level in the top bit of the program counter. The guard takes the effective address produced by the address adder, the kind of access being made and the current privilege level. It then decides which address reaches memory and whether the access may go ahead.

Kernel code reaches the full address space unchanged. For user code, a build-time parameter selects one of two policies:

- **Alias policy.** The top address bit is cleared, so every upper-half address lands on its lower-half twin. The kernel half is never touched and nothing is reported.
- **Fault policy.** The same condition blocks the access. The guard drops the memory enable and the write enable, and tells the register-writeback stage to discard a load result. One cycle later it raises a trap request, which the sequencer routes to the illegal-operation entry.

Top module: `eag_guard`

## Requirements
- R1: With `priv_kernel`=0 and a memory access (load, PC-relative load or store), `mem_addr` equals `eff_addr` with bit 31 cleared. For example, 0x80000030 becomes 0x00000030.
- R2: With `priv_kernel`=1, `mem_addr` equals `eff_addr` unchanged, for every access kind.
- R3: In alias policy (`FAULT_MODE`=0), a user access to the upper half goes ahead on the folded address. `mem_en` is 1, `load_kill` is 0 and `prot_trap` stays 0. For example, a user load of 0x80001000 reads 0x00001000.
- R4: Access kind encoding on `acc_kind` is 0 none, 1 load, 2 PC-relative load and 3 store. Kind 0 keeps `mem_en`, `mem_we` and `load_kill` at 0, and the following cycle's `prot_trap` at 0.
- R5: `mem_we` is 1 only for an enabled store. Loads and PC-relative loads drive `mem_en`=1 with `mem_we`=0.
- R6: In fault policy, a user access whose address bit 31 is 1 drives `mem_en`=0 and `mem_we`=0.
- R7: In fault policy, a blocked load or PC-relative load drives `load_kill`=1 in the same cycle. A blocked store leaves `load_kill` at 0.
- R8: In fault policy, `prot_trap` is 1 in the cycle after a blocked access, and 0 in the cycle after any other input. Reset clears it.
- R9: In fault policy, user accesses to the lower half and all kernel accesses proceed as in R1, R2 and R5, with no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv_kernel | input | 1 | Privilege flag, 1 = kernel |
| acc_kind | input | 2 | Access kind: 0 none, 1 load, 2 PC-relative load, 3 store |
| eff_addr | input | AW | Effective address from the adder |
| mem_addr | output | AW | Address presented to data memory |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| load_kill | output | 1 | Suppress the destination-register write of this load |
| prot_trap | output | 1 | Registered protection-trap request |

## Verification
The assertions check four properties on every cycle:

- A user access never carries bit 31 to memory.
- Kernel addresses pass through untouched.
- The write enable only accompanies an enabled store.
- In fault policy, a blocked access never reaches memory, and a trap is always preceded by a violating access one cycle earlier.

Some behaviours can only be shown by the bench's scenarios, which run both policies side by side on the same stimulus:

- The exact folded address values.
- That back-to-back violations hold the trap for consecutive cycles.
- That alias policy lets an upper-half user access through on its twin address.
- That reset clears a pending trap.

// File: rtl/eag_pkg.sv
package eag_pkg;

  typedef enum logic [1:0] {
    ACC_NONE   = 2'd0,
    ACC_LOAD   = 2'd1,
    ACC_LOADPC = 2'd2,
    ACC_STORE  = 2'd3
  } acc_e;

  function automatic logic touches_mem(input acc_e k);
    return k != ACC_NONE;
  endfunction

  function automatic logic writes_mem(input acc_e k);
    return k == ACC_STORE;
  endfunction

endpackage

// File: rtl/eag_decode.sv
module eag_decode
  import eag_pkg::*;
(
  input  logic [1:0] acc_kind,
  output logic       is_mem,
  output logic       is_store
);
  acc_e kind;

  always_comb begin
    kind     = acc_e'(acc_kind);
    is_mem   = touches_mem(kind);
    is_store = writes_mem(kind);
  end
endmodule

// File: rtl/eag_remap.sv
module eag_remap #(
  parameter int AW = 32
) (
  input  logic          priv_kernel,
  input  logic [AW-1:0] ea,
  output logic [AW-1:0] addr_out,
  output logic          upper_half
);
  localparam logic [AW-1:0] LOW_MASK = {1'b0, {(AW-1){1'b1}}};

  always_comb begin
    upper_half = ea[AW-1];
    addr_out   = priv_kernel ? ea : (ea & LOW_MASK);
  end
endmodule

// File: rtl/eag_trap_reg.sv
module eag_trap_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d;
  end
endmodule

// File: rtl/eag_guard.sv
module eag_guard #(
  parameter int AW         = 32,
  parameter bit FAULT_MODE = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          priv_kernel,
  input  logic [1:0]    acc_kind,
  input  logic [AW-1:0] eff_addr,
  output logic [AW-1:0] mem_addr,
  output logic          mem_en,
  output logic          mem_we,
  output logic          load_kill,
  output logic          prot_trap
);
  logic is_mem_w, is_store_w, upper_w;
  logic viol_w;   // user access aimed at the kernel half
  logic block_w;  // access actually suppressed

  eag_decode u_dec (
    .acc_kind (acc_kind),
    .is_mem   (is_mem_w),
    .is_store (is_store_w)
  );

  eag_remap #(.AW(AW)) u_map (
    .priv_kernel (priv_kernel),
    .ea          (eff_addr),
    .addr_out    (mem_addr),
    .upper_half  (upper_w)
  );

  assign viol_w = is_mem_w & ~priv_kernel & upper_w;

  generate
    if (FAULT_MODE) begin : g_fault
      assign block_w = viol_w;
    end else begin : g_alias
      assign block_w = 1'b0;
    end
  endgenerate

  always_comb begin
    mem_en    = is_mem_w & ~block_w;
    mem_we    = is_store_w & ~block_w;
    load_kill = block_w & ~is_store_w;
  end

  eag_trap_reg u_trap (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (block_w),
    .q     (prot_trap)
  );
endmodule

// File: rtl/eag_guard_chk.sv
module eag_guard_chk #(
  parameter int AW         = 32,
  parameter bit FAULT_MODE = 1'b0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          priv_kernel,
  input logic [1:0]    acc_kind,
  input logic [AW-1:0] eff_addr,
  input logic [AW-1:0] mem_addr,
  input logic          mem_en,
  input logic          mem_we,
  input logic          load_kill,
  input logic          prot_trap,
  input logic          viol
);
  // R1
  user_msb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !priv_kernel) |-> !mem_addr[AW-1]);

  // R2
  kernel_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    priv_kernel |-> (mem_addr == eff_addr));

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind == 2'd0) |-> (!mem_en && !mem_we && !load_kill));

  // R5
  we_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_en && acc_kind == 2'd3));

  generate
    if (FAULT_MODE) begin : g_fault_chk
      // R6
      fault_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> (!mem_en && !mem_we));
      // R8
      trap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prot_trap |-> $past(viol));
    end else begin : g_alias_chk
      // R3
      alias_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> (mem_en && !load_kill));
      // R3
      alias_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_trap);
    end
  endgenerate
endmodule

bind eag_guard eag_guard_chk #(.AW(AW), .FAULT_MODE(FAULT_MODE)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .priv_kernel (priv_kernel),
  .acc_kind    (acc_kind),
  .eff_addr    (eff_addr),
  .mem_addr    (mem_addr),
  .mem_en      (mem_en),
  .mem_we      (mem_we),
  .load_kill   (load_kill),
  .prot_trap   (prot_trap),
  .viol        (viol_w)
);

// File: tb/eag_guard_test.sv
module eag_guard_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        priv_kernel = 1'b0;
  logic [1:0]  acc_kind = 2'd0;
  logic [31:0] eff_addr = 32'd0;

  logic [31:0] a_addr, f_addr;
  logic        a_en, a_we, a_kill, a_trap;
  logic        f_en, f_we, f_kill, f_trap;

  int checks = 0;
  int errors = 0;
  bit f_trap_next = 1'b0;  // model: trap expected in the next step

  always #2 clk = ~clk;

  eag_guard #(.AW(32), .FAULT_MODE(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .priv_kernel(priv_kernel), .acc_kind(acc_kind),
    .eff_addr(eff_addr), .mem_addr(a_addr), .mem_en(a_en), .mem_we(a_we),
    .load_kill(a_kill), .prot_trap(a_trap));

  eag_guard #(.AW(32), .FAULT_MODE(1'b1)) uut_f (
    .clk(clk), .rst_n(rst_n), .priv_kernel(priv_kernel), .acc_kind(acc_kind),
    .eff_addr(eff_addr), .mem_addr(f_addr), .mem_en(f_en), .mem_we(f_we),
    .load_kill(f_kill), .prot_trap(f_trap));

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drive one access, then compare both policies with the behavioural model.
  task automatic step(input bit k, input logic [1:0] kind, input logic [31:0] ea,
                      input string req);
    bit mem, st, bad;
    logic [31:0] want;
    @(negedge clk);
    priv_kernel = k; acc_kind = kind; eff_addr = ea;
    #1;
    mem  = (kind != 2'd0);
    st   = (kind == 2'd3);
    want = k ? ea : {1'b0, ea[30:0]};
    bad  = mem && !k && ea[31];
    // alias policy (R1 R2 R3 R4 R5)
    chk(req, "alias addr", a_addr, want);
    chk(req, "alias en",   {31'd0, a_en},   {31'd0, mem});
    chk(req, "alias we",   {31'd0, a_we},   {31'd0, st});
    chk(req, "alias kill", {31'd0, a_kill}, 32'd0);
    chk(req, "alias trap", {31'd0, a_trap}, 32'd0);
    // fault policy (R6 R7 R8 R9)
    chk(req, "fault addr", f_addr, want);
    chk(req, "fault en",   {31'd0, f_en},   {31'd0, mem && !bad});
    chk(req, "fault we",   {31'd0, f_we},   {31'd0, st && !bad});
    chk(req, "fault kill", {31'd0, f_kill}, {31'd0, bad && !st});
    chk(req, "fault trap", {31'd0, f_trap}, {31'd0, f_trap_next});
    f_trap_next = bad;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state (R8)
    chk("R8", "reset alias trap", {31'd0, a_trap}, 32'd0);
    chk("R8", "reset fault trap", {31'd0, f_trap}, 32'd0);
    rst_n = 1'b1;

    step(1'b0, 2'd1, 32'h8000_0030, "R1");  // user load, folded
    step(1'b0, 2'd2, 32'h8000_1000, "R3");  // user pc-rel load, alias to 0x1000
    step(1'b0, 2'd3, 32'hFFFF_FFFC, "R6");  // user store upper, fault blocks
    step(1'b0, 2'd0, 32'h8000_0000, "R4");  // idle with upper address
    step(1'b1, 2'd1, 32'h8000_1234, "R2");  // kernel load unchanged
    step(1'b1, 2'd3, 32'h8000_0008, "R5");  // kernel store
    step(1'b1, 2'd0, 32'hDEAD_BEEF, "R2");  // kernel idle, passes through
    step(1'b0, 2'd3, 32'h0000_2044, "R9");  // user store lower, fine
    step(1'b0, 2'd1, 32'h8000_0004, "R7");  // back-to-back violations
    step(1'b0, 2'd2, 32'hC000_0000, "R7");
    step(1'b0, 2'd3, 32'h8000_0010, "R8");
    step(1'b0, 2'd1, 32'h7FFF_FFFF, "R9");  // lower edge, trap from prior
    step(1'b0, 2'd0, 32'h0000_0000, "R8");

    // Reset clears a pending trap (R8).
    step(1'b0, 2'd1, 32'h8000_0000, "R8");
    @(negedge clk);
    acc_kind = 2'd0;
    rst_n = 1'b0;
    #1;
    chk("R8", "trap after reset", {31'd0, f_trap}, 32'd0);
    f_trap_next = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 40; i++) begin
      step(i[0], i[2:1], {i[3], 3'b000, i[7:4], 24'h00_1230}, "R1");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule